// File: doc/BRIEF.md
# DMA Channel Event Latch and Priority Arbiter

This block sits in front of a DMA transfer engine. It records requests for 64 channels in an event register. A request can come from a dedicated hardware event line, from a chain-trigger line driven when another channel finishes, or from software through a set register. Each cycle it selects one channel that is both pending and enabled, and offers that channel to the transfer engine with a valid/ready handshake. A chain trigger only marks the target channel as pending. It does not touch that channel's transfer configuration.

Software reaches five 64-bit registers through a simple single-cycle bus. One write port (enable, address, data) and one combinational read port (address, data) give access to the event, missed-event, enable, clear and set registers. Each channel has a 3-bit priority level taken from a flat input vector. The highest level wins, and a tie goes to the lowest channel number.

The grant controller has two named states. SCAN looks for a winner. On the transition SCAN->OFFER, taken when any channel is pending and enabled, the winner is registered. OFFER holds the offer until it is accepted. On the transition OFFER->SCAN, taken when `gnt_ready` is high, the granted event bit is removed.

Top module: `dma_evt_arb`

## Requirements
- R1: A high level on `hw_evt[n]` or `chain_evt[n]` during a clock edge makes event bit n read as 1 (read address 0) after that edge.
- R2: A write to address 4 (set) sets every event bit whose data bit is 1 and leaves the others unchanged.
- R3: A write to address 3 (clear) clears every event bit and missed bit whose data bit is 1. When a hardware or chain event hits the same bit in the same cycle, the event bit stays 1.
- R4: A channel is offered only if its enable bit (read/write at address 2) is 1. A channel that is pending but disabled is never offered.
- R5: Among pending and enabled channels, the one offered has the highest priority level `chan_prio[3n+2:3n]`. A tie goes to the lowest channel number.
- R6: Once `gnt_valid` rises, it stays high with `gnt_ch` unchanged until a cycle in which `gnt_ready` is high. At that edge the granted event bit is cleared, unless a new event for it arrives in the same cycle. The next offer comes at least one idle cycle later.
- R7: A hardware or chain event on a bit that is already set, and that is not being accepted in that cycle, sets missed bit n (read at address 1). This also holds when a clear write hits the same bit in the same cycle.
- R8: Writes to addresses 0 and 1 have no effect. Reads of addresses 3, 4 and 5 to 7 return 0.
- R9: After reset, all registers read 0 and `gnt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Write address: 0 event, 1 missed, 2 enable, 3 clear, 4 set |
| reg_wr_data | input | 64 | Write data, one bit per channel |
| reg_rd_addr | input | 3 | Read address |
| reg_rd_data | output | 64 | Combinational read data |
| hw_evt | input | 64 | Hardware event lines, one per channel |
| chain_evt | input | 64 | Chain triggers from completing channels |
| chan_prio | input | 192 | 3-bit priority level per channel, channel n at bits 3n+2:3n |
| gnt_valid | output | 1 | A granted channel is offered |
| gnt_ch | output | 6 | Offered channel number |
| gnt_ready | input | 1 | Transfer engine accepts the offer |

## Verification
The hardest cases to reach are those where several things land on one bit in one cycle: a clear write and a new event together, or a new event on a bit that is already pending while its offer is stalled. The stimulus holds `gnt_ready` low, so a channel stays pending under an open offer. It then drives the clear write and the event line on the same negative edge. Afterwards it reads back both the event and missed registers. A behavioural model in the bench follows every edge, so each offer and each idle cycle is compared in every clock.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
    typedef enum logic [2:0] {
        REG_EVT  = 3'd0,
        REG_MISS = 3'd1,
        REG_EN   = 3'd2,
        REG_CLR  = 3'd3,
        REG_SET  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        ARB_SCAN,
        ARB_OFFER
    } arb_state_e;
endpackage

// File: rtl/dma_evt_latch.sv
module dma_evt_latch
    import dma_evt_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int ADDR_W = 3,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NUM_CH-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NUM_CH-1:0] rd_data,
    input  logic [NUM_CH-1:0] hw_evt,
    input  logic [NUM_CH-1:0] chain_evt,
    input  logic              take_valid,
    input  logic [CH_W-1:0]   take_ch,
    output logic [NUM_CH-1:0] evt_q,
    output logic [NUM_CH-1:0] en_q
);
    logic [NUM_CH-1:0] mis_q;
    logic [NUM_CH-1:0] set_v, clr_v, hw_v, new_v, take_v;

    always_comb begin
        set_v  = (wr_en && wr_addr == ADDR_W'(REG_SET)) ? wr_data : '0;
        clr_v  = (wr_en && wr_addr == ADDR_W'(REG_CLR)) ? wr_data : '0;
        hw_v   = hw_evt | chain_evt;
        new_v  = hw_v | set_v;
        take_v = take_valid ? (NUM_CH'(1) << take_ch) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
            mis_q <= '0;
            en_q  <= '0;
        end else begin
            evt_q <= (evt_q & ~clr_v & ~take_v) | new_v;
            mis_q <= (mis_q & ~clr_v) | (hw_v & evt_q & ~take_v);
            if (wr_en && wr_addr == ADDR_W'(REG_EN))
                en_q <= wr_data;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_W'(REG_EVT):  rd_data = evt_q;
            ADDR_W'(REG_MISS): rd_data = mis_q;
            ADDR_W'(REG_EN):   rd_data = en_q;
            default:           rd_data = '0;
        endcase
    end

    p_hw_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        |hw_v |=> ((evt_q & $past(hw_v)) == $past(hw_v)));

    p_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(REG_SET)) |=> ((evt_q & $past(wr_data)) == $past(wr_data)));

    p_sw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(REG_CLR)) |=> ((evt_q & $past(wr_data & ~new_v)) == '0));

    p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && !new_v[take_ch]) |=> !evt_q[$past(take_ch)]);
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NUM_CH = 64,
    parameter int PRIO_W = 3,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] prio,
    output logic                     any,
    output logic [CH_W-1:0]          win_ch
);
    logic [PRIO_W-1:0] best_lvl;

    always_comb begin
        any      = 1'b0;
        win_ch   = '0;
        best_lvl = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && (!any || prio[i*PRIO_W +: PRIO_W] > best_lvl)) begin
                any      = 1'b1;
                win_ch   = CH_W'(i);
                best_lvl = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/dma_grant_fsm.sv
module dma_grant_fsm
    import dma_evt_pkg::*;
#(
    parameter int NUM_CH = 64,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any,
    input  logic [CH_W-1:0] win_ch,
    input  logic            gnt_ready,
    output logic            gnt_valid,
    output logic [CH_W-1:0] gnt_ch,
    output logic            take_valid
);
    arb_state_e state_q, state_d;
    logic [CH_W-1:0] ch_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_SCAN:  if (any)       state_d = ARB_OFFER;
            ARB_OFFER: if (gnt_ready) state_d = ARB_SCAN;
            default:                  state_d = ARB_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_SCAN;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_SCAN && any)
                ch_q <= win_ch;
        end
    end

    always_comb begin
        gnt_valid  = (state_q == ARB_OFFER);
        gnt_ch     = ch_q;
        take_valid = gnt_valid && gnt_ready;
    end

    p_offer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_ch)));

    p_idle_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |=> !gnt_valid);
endmodule

// File: rtl/dma_evt_arb.sv
module dma_evt_arb
    import dma_evt_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 3,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr_en,
    input  logic [ADDR_W-1:0]        reg_wr_addr,
    input  logic [NUM_CH-1:0]        reg_wr_data,
    input  logic [ADDR_W-1:0]        reg_rd_addr,
    output logic [NUM_CH-1:0]        reg_rd_data,
    input  logic [NUM_CH-1:0]        hw_evt,
    input  logic [NUM_CH-1:0]        chain_evt,
    input  logic [NUM_CH*PRIO_W-1:0] chan_prio,
    output logic                     gnt_valid,
    output logic [CH_W-1:0]          gnt_ch,
    input  logic                     gnt_ready
);
    logic [NUM_CH-1:0] evt_q, en_q, req;
    logic              any, take_valid;
    logic [CH_W-1:0]   win_ch;

    assign req = evt_q & en_q;

    dma_evt_latch #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) latch_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .hw_evt(hw_evt), .chain_evt(chain_evt),
        .take_valid(take_valid), .take_ch(gnt_ch),
        .evt_q(evt_q), .en_q(en_q)
    );

    dma_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) pick_i (
        .req(req), .prio(chan_prio), .any(any), .win_ch(win_ch)
    );

    dma_grant_fsm #(.NUM_CH(NUM_CH)) fsm_i (
        .clk(clk), .rst_n(rst_n), .any(any), .win_ch(win_ch),
        .gnt_ready(gnt_ready), .gnt_valid(gnt_valid), .gnt_ch(gnt_ch),
        .take_valid(take_valid)
    );

    logic [NUM_CH-1:0] req_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_prev <= '0;
        else        req_prev <= req;
    end

    p_offer_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> req_prev[gnt_ch]);
endmodule

// File: tb/dma_evt_arb_tb.sv
module dma_evt_arb_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [2:0] reg_wr_addr = '0;
    logic [63:0] reg_wr_data = '0;
    logic [2:0] reg_rd_addr = '0;
    logic [63:0] reg_rd_data;
    logic [63:0] hw_evt = '0;
    logic [63:0] chain_evt = '0;
    logic [191:0] chan_prio = '0;
    logic gnt_valid;
    logic [5:0] gnt_ch;
    logic gnt_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    int acc_q[$];

    always #5 clk = ~clk;

    dma_evt_arb dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .hw_evt(hw_evt), .chain_evt(chain_evt), .chan_prio(chan_prio),
        .gnt_valid(gnt_valid), .gnt_ch(gnt_ch), .gnt_ready(gnt_ready)
    );

    // behavioural reference
    logic [63:0] m_evt, m_mis, m_en;
    bit m_off;
    int m_ch;

    function automatic int lvl(int ch);
        return int'(chan_prio[ch*3 +: 3]);
    endfunction

    function automatic int pick(logic [63:0] r);
        int best = -1;
        int bl = -1;
        for (int i = 0; i < 64; i++)
            if (r[i] && lvl(i) > bl) begin bl = lvl(i); best = i; end
        return best;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_evt = '0; m_mis = '0; m_en = '0; m_off = 0; m_ch = 0;
        end else begin
            logic [63:0] hw, clr, st, gclr;
            int w;
            bit acc;
            acc  = m_off && gnt_ready;
            hw   = hw_evt | chain_evt;
            clr  = (reg_wr_en && reg_wr_addr == 3'd3) ? reg_wr_data : 64'd0;
            st   = (reg_wr_en && reg_wr_addr == 3'd4) ? reg_wr_data : 64'd0;
            gclr = acc ? (64'd1 << m_ch) : 64'd0;
            w    = pick(m_evt & m_en);
            if (m_off) begin
                if (acc) m_off = 0;
            end else if (w >= 0) begin
                m_off = 1; m_ch = w;
            end
            m_mis = (m_mis & ~clr) | (hw & m_evt & ~gclr);
            m_evt = (m_evt & ~clr & ~gclr) | hw | st;
            if (reg_wr_en && reg_wr_addr == 3'd2) m_en = reg_wr_data;
        end
    end

    always @(posedge clk) begin
        if (rst_n && gnt_valid && gnt_ready) acc_q.push_back(int'(gnt_ch));
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (gnt_valid !== m_off || (m_off && gnt_ch !== 6'(m_ch))) begin
                failures++;
                $display("FAIL R5/R6 per-cycle grant: actual valid=%0b ch=%0d expected valid=%0b ch=%0d",
                         gnt_valid, gnt_ch, m_off, m_ch);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(string tag, logic [2:0] a, logic [63:0] exp);
        @(negedge clk);
        reg_rd_addr = a;
        #1;
        chk(tag, reg_rd_data, exp);
    endtask

    task automatic wr(logic [2:0] a, logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    task automatic pulse_hw(logic [63:0] m);
        @(negedge clk); hw_evt = m;
        @(negedge clk); hw_evt = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] b(int n);
        return 64'd1 << n;
    endfunction

    initial begin
        chan_prio[40*3 +: 3] = 3'd5;
        chan_prio[5*3 +: 3]  = 3'd2;
        chan_prio[9*3 +: 3]  = 3'd2;
        chan_prio[63*3 +: 3] = 3'd7;
        chan_prio[1*3 +: 3]  = 3'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        for (int a = 0; a < 5; a++) rd("R9 reset read", 3'(a), 64'd0);
        chk("R9 valid after reset", {63'd0, gnt_valid}, 64'd0);

        // R8 read-only addresses ignore writes
        wr(3'd0, '1);
        wr(3'd1, '1);
        rd("R8 event ignores write", 3'd0, 64'd0);
        rd("R8 missed ignores write", 3'd1, 64'd0);

        wr(3'd2, b(1) | b(5) | b(9) | b(20) | b(40) | b(63));
        rd("R4 enable readback", 3'd2, b(1) | b(5) | b(9) | b(20) | b(40) | b(63));
        rd("R8 clear reads zero", 3'd3, 64'd0);
        rd("R8 set reads zero", 3'd4, 64'd0);
        rd("R8 unused reads zero", 3'd6, 64'd0);

        // R1 / R5: three events together, engine stalled
        gnt_ready = 1'b0;
        pulse_hw(b(5) | b(9) | b(40));
        rd("R1 events latched", 3'd0, b(5) | b(9) | b(40));
        idle(2);
        chk("R5 highest level first", {58'd0, gnt_ch}, 64'd40);
        idle(4);
        chk("R6 offer held valid", {63'd0, gnt_valid}, 64'd1);
        chk("R6 offer held channel", {58'd0, gnt_ch}, 64'd40);
        @(negedge clk); gnt_ready = 1'b1;
        idle(10);
        chk("R5 grant count", 64'(acc_q.size()), 64'd3);
        if (acc_q.size() == 3) begin
            chk("R5 order first", 64'(acc_q[0]), 64'd40);
            chk("R5 tie lowest second", 64'(acc_q[1]), 64'd5);
            chk("R5 tie third", 64'(acc_q[2]), 64'd9);
        end
        rd("R6 accepted bits cleared", 3'd0, 64'd0);
        acc_q.delete();

        // R4 disabled channel stays pending, never offered
        pulse_hw(b(12));
        idle(5);
        chk("R4 disabled not offered", {63'd0, gnt_valid}, 64'd0);
        rd("R4 disabled still pending", 3'd0, b(12));
        // R7 second event on pending bit
        pulse_hw(b(12));
        rd("R7 missed set", 3'd1, b(12));
        wr(3'd3, b(12));
        rd("R3 clear event", 3'd0, 64'd0);
        rd("R3 clear missed", 3'd1, 64'd0);

        // R3 clear and event in same cycle, offer stalled
        gnt_ready = 1'b0;
        pulse_hw(b(20));
        idle(3);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = 3'd3; reg_wr_data = b(20); hw_evt = b(20);
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0; hw_evt = '0;
        rd("R3 new event wins over clear", 3'd0, b(20));
        rd("R7 missed despite clear", 3'd1, b(20));
        wr(3'd3, b(20));
        rd("R3 plain clear", 3'd0, 64'd0);
        @(negedge clk); gnt_ready = 1'b1;
        idle(4);
        acc_q.delete();

        // R2 software set
        wr(3'd4, b(63));
        idle(5);
        chk("R2 set grant", 64'(acc_q.size()), 64'd1);
        if (acc_q.size() == 1) chk("R2 set channel", 64'(acc_q[0]), 64'd63);
        acc_q.delete();

        // R1 chain trigger
        @(negedge clk); chain_evt = b(1);
        @(negedge clk); chain_evt = '0;
        idle(5);
        chk("R1 chain grant", 64'(acc_q.size()), 64'd1);
        if (acc_q.size() == 1) chk("R1 chain channel", 64'(acc_q[0]), 64'd1);
        rd("R1 chain bit consumed", 3'd0, 64'd0);

        idle(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule